// File: doc/BRIEF.md
# Data-Bus Segment Pointer Pair

This block keeps two small pointers that decide which 16-bit slice of a 64-bit internal word a narrow data bus reaches. One pointer serves data reads and the other serves data writes. Each pointer has a lower bound, an upper bound and a present position, so a host can walk any run of slices of a wide word one bus cycle at a time. Each pointer moves on after every completed data cycle of its own direction.

The three fields of both pointers live in one 16-bit configuration word. The host can write that word and read it back at any time. A separate reload command puts both positions back at their lower bounds without touching the bounds, which is how an interrupted transfer is restarted. The block also steers the read slice onto the bus and gives a one-hot write lane enable. It raises a one-cycle kick after any write into the highest slice, so the surrounding logic can start a compare once a wide register has been filled.

The stepping rule is short. A pointer that sits on its upper bound goes to its lower bound on its next step. Otherwise it adds one, modulo four. A position above the upper bound therefore climbs to 3, wraps to 0 and climbs on to the upper bound. A lower bound above the upper bound behaves in the same way.

Top module: `segptr_unit`

## Requirements
- R1: In the cycle after synchronous reset, both pointers have position 0, lower bound 0 and upper bound 3, `cfg_rdata` reads 16'h1818, and `cmp_kick` is 0.
- R2: A pointer changes position only after a data cycle of its own direction. `rd_cycle` never moves `wr_seg`, `wr_cycle` never moves `rd_seg`, and one data cycle moves a pointer by exactly one step.
- R3: On a step, a position equal to the upper bound becomes the lower bound. Any other position becomes position+1 modulo 4, so a position above the upper bound runs up to 3, wraps to 0 and continues up to the upper bound.
- R4: When the lower bound is greater than the upper bound, a pointer on its upper bound jumps to the lower bound and then steps through 3 and 0 back up to the upper bound.
- R5: A pulse on `rsc_cmd` sets the read position to the read lower bound and the write position to the write lower bound. All four bounds are left unchanged.
- R6: The configuration word holds the fields at these bit positions: read position [1:0], read upper bound [4:3], read lower bound [7:6], write position [9:8], write upper bound [12:11], write lower bound [14:13]. A write with `cfg_wr` loads all six fields, and `cfg_rdata` returns them in the same places.
- R7: Bits 15, 10, 5 and 2 of `cfg_rdata` always read 0, whatever was written.
- R8: When several actions fall in one cycle, a configuration write wins over `rsc_cmd`, and `rsc_cmd` wins over a data-cycle step.
- R9: `rd_data` equals slice `rd_seg` of `rd_word` (bits 16*rd_seg+15 down to 16*rd_seg). `wr_lane` is one-hot with bit `wr_seg` set.
- R10: `cmp_kick` is 1 for exactly the one cycle after a write data cycle taken while `wr_seg` was 3, and 0 at all other times. Read cycles never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the configuration word from `cfg_wdata` |
| cfg_wdata | input | 16 | Configuration word to load |
| cfg_rdata | output | 16 | Present configuration word |
| rsc_cmd | input | 1 | Reload both positions from their lower bounds |
| rd_cycle | input | 1 | A data read cycle completes this clock |
| wr_cycle | input | 1 | A data write cycle completes this clock |
| rd_word | input | 64 | Wide word the read pointer selects from |
| rd_data | output | 16 | Slice of `rd_word` picked by the read pointer |
| wr_lane | output | 4 | One-hot write slice enable |
| rd_seg | output | 2 | Read pointer position |
| wr_seg | output | 2 | Write pointer position |
| cmp_kick | output | 1 | One-cycle pulse after a write into slice 3 |

## Verification
The bench builds the block with its default parameters: a 16-bit bus slice and four slices per word. With only four positions, every combination of position and bounds can be reached with a few directed writes. This covers positions above the upper bound, a lower bound above the upper bound, and positions already at 3 that must wrap. Lane steering is checked on all four slices, and the kick is checked on both sides of the highest slice.

// File: rtl/segptr_pkg.sv
package segptr_pkg;

    localparam int SEG_CNT  = 4;
    localparam int PTR_W    = $clog2(SEG_CNT);
    localparam int CFG_W    = 16;
    localparam int CTR_CNT  = 2;
    localparam int RD_IDX   = 0;
    localparam int WR_IDX   = 1;

    typedef logic [PTR_W-1:0] seg_t;

    localparam seg_t LAST_SEG = seg_t'(SEG_CNT - 1);

    typedef struct packed {
        seg_t cur;
        seg_t lo;
        seg_t hi;
    } ctr_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_LOAD   = 2'd3
    } ctr_act_e;

    localparam ctr_t CTR_RESET = '{cur: '0, lo: '0, hi: LAST_SEG};

    // Next position after one data cycle.
    function automatic seg_t seg_step(ctr_t c);
        if (c.cur == c.hi) return c.lo;
        return seg_t'(c.cur + seg_t'(1));
    endfunction

    // Field extraction; idx selects the read (0) or write (1) half.
    function automatic ctr_t cfg_unpack(logic [CFG_W-1:0] v, int idx);
        ctr_t c;
        if (idx == RD_IDX) begin
            c.cur = v[1:0];
            c.hi  = v[4:3];
            c.lo  = v[7:6];
        end else begin
            c.cur = v[9:8];
            c.hi  = v[12:11];
            c.lo  = v[14:13];
        end
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(ctr_t r, ctr_t w);
        return {1'b0, w.lo, w.hi, 1'b0, w.cur, r.lo, 1'b0, r.hi, 1'b0, r.cur};
    endfunction

    function automatic ctr_act_e pick_act(logic ld, logic rl, logic st);
        if (ld) return ACT_LOAD;
        if (rl) return ACT_RELOAD;
        if (st) return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/segptr_ctr.sv
module segptr_ctr
    import segptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctr_act_e act,
    input  ctr_t     load_val,
    output ctr_t     state
);
    ctr_t state_q;
    ctr_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_LOAD:   state_d = load_val;
            ACT_RELOAD: state_d.cur = state_q.lo;
            ACT_STEP:   state_d.cur = seg_step(state_q);
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CTR_RESET;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/segptr_steer.sv
module segptr_steer
    import segptr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W*SEG_CNT-1:0] rd_word,
    input  seg_t                      rd_sel,
    input  seg_t                      wr_sel,
    output logic [DATA_W-1:0]         rd_data,
    output logic [SEG_CNT-1:0]        wr_lane
);
    logic [DATA_W-1:0] slice [SEG_CNT];

    for (genvar k = 0; k < SEG_CNT; k++) begin : g_lane
        assign slice[k]   = rd_word[k*DATA_W +: DATA_W];
        assign wr_lane[k] = (wr_sel == seg_t'(k));
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < SEG_CNT; k++) begin
            if (rd_sel == seg_t'(k)) rd_data = slice[k];
        end
    end
endmodule

// File: rtl/segptr_unit.sv
module segptr_unit
    import segptr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int WORD_W = DATA_W * SEG_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              rsc_cmd,
    input  logic              rd_cycle,
    input  logic              wr_cycle,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEG_CNT-1:0] wr_lane,
    output logic [PTR_W-1:0]  rd_seg,
    output logic [PTR_W-1:0]  wr_seg,
    output logic              cmp_kick
);
    ctr_t     ctr_st [CTR_CNT];
    ctr_act_e ctr_act [CTR_CNT];
    logic     ctr_cyc [CTR_CNT];
    logic     kick_q;

    assign ctr_cyc[RD_IDX] = rd_cycle;
    assign ctr_cyc[WR_IDX] = wr_cycle;

    for (genvar g = 0; g < CTR_CNT; g++) begin : g_ctr
        assign ctr_act[g] = pick_act(cfg_wr, rsc_cmd, ctr_cyc[g]);
        segptr_ctr u_ctr (
            .clk      (clk),
            .rst      (rst),
            .act      (ctr_act[g]),
            .load_val (cfg_unpack(cfg_wdata, g)),
            .state    (ctr_st[g])
        );
    end

    assign rd_seg    = ctr_st[RD_IDX].cur;
    assign wr_seg    = ctr_st[WR_IDX].cur;
    assign cfg_rdata = cfg_pack(ctr_st[RD_IDX], ctr_st[WR_IDX]);

    segptr_steer #(.DATA_W(DATA_W)) u_steer (
        .rd_word (rd_word),
        .rd_sel  (ctr_st[RD_IDX].cur),
        .wr_sel  (ctr_st[WR_IDX].cur),
        .rd_data (rd_data),
        .wr_lane (wr_lane)
    );

    always_ff @(posedge clk) begin
        if (rst) kick_q <= 1'b0;
        else     kick_q <= wr_cycle && (ctr_st[WR_IDX].cur == LAST_SEG);
    end

    assign cmp_kick = kick_q;
endmodule

// File: rtl/segptr_unit_chk.sv
module segptr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        rsc_cmd,
    input logic        rd_cycle,
    input logic        wr_cycle,
    input logic [15:0] cfg_rdata,
    input logic [3:0]  wr_lane,
    input logic [1:0]  rd_seg,
    input logic [1:0]  wr_seg,
    input logic        cmp_kick
);
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_cycle && !cfg_wr && !rsc_cmd) |=> $stable(rd_seg));

    p_wr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_cycle && !cfg_wr && !rsc_cmd) |=> $stable(wr_seg));

    p_rd_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_cycle && !cfg_wr && !rsc_cmd && rd_seg != cfg_rdata[4:3])
        |=> rd_seg == 2'($past(rd_seg) + 2'd1));

    p_rd_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_cycle && !cfg_wr && !rsc_cmd && rd_seg == cfg_rdata[4:3])
        |=> rd_seg == $past(cfg_rdata[7:6]));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (rsc_cmd && !cfg_wr) |=> (rd_seg == $past(cfg_rdata[7:6]))
                               && (wr_seg == $past(cfg_rdata[14:13])));

    p_zero_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] | cfg_rdata[10] | cfg_rdata[5] | cfg_rdata[2]) == 1'b0);

    p_lane_r9: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_lane) == 1) && wr_lane[wr_seg]);

    p_kick_r10: assert property (@(posedge clk) disable iff (rst)
        cmp_kick |-> ($past(wr_cycle) && $past(wr_seg) == 2'd3));
endmodule

bind segptr_unit segptr_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .rsc_cmd   (rsc_cmd),
    .rd_cycle  (rd_cycle),
    .wr_cycle  (wr_cycle),
    .cfg_rdata (cfg_rdata),
    .wr_lane   (wr_lane),
    .rd_seg    (rd_seg),
    .wr_seg    (wr_seg),
    .cmp_kick  (cmp_kick)
);

// File: tb/segptr_unit_tb.sv
module segptr_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        rsc_cmd;
    logic        rd_cycle;
    logic        wr_cycle;
    logic [63:0] rd_word;
    logic [15:0] rd_data;
    logic [3:0]  wr_lane;
    logic [1:0]  rd_seg;
    logic [1:0]  wr_seg;
    logic        cmp_kick;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    segptr_unit u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rsc_cmd(rsc_cmd), .rd_cycle(rd_cycle),
        .wr_cycle(wr_cycle), .rd_word(rd_word), .rd_data(rd_data),
        .wr_lane(wr_lane), .rd_seg(rd_seg), .wr_seg(wr_seg), .cmp_kick(cmp_kick)
    );

    function automatic logic [15:0] pk(logic [1:0] rc, logic [1:0] rh, logic [1:0] rl,
                                       logic [1:0] wc, logic [1:0] wh, logic [1:0] wl);
        return {1'b0, wl, wh, 1'b0, wc, rl, 1'b0, rh, 1'b0, rc};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cfg_wr = 0; rsc_cmd = 0; rd_cycle = 0; wr_cycle = 0;
    endtask

    task automatic load(logic [15:0] v);
        cfg_wr = 1; cfg_wdata = v;
        cyc();
    endtask

    task automatic rd_step(logic [1:0] exp, string req);
        rd_cycle = 1;
        cyc();
        chk(req, rd_seg, exp);
    endtask

    task automatic wr_step(logic [1:0] exp, string req);
        wr_cycle = 1;
        cyc();
        chk(req, wr_seg, exp);
    endtask

    task automatic t_reset();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        cyc();
        chk("R1 cfg", cfg_rdata, 16'h1818);
        chk("R1 cfg pack", cfg_rdata, pk(0, 3, 0, 0, 3, 0));
        chk("R1 kick", cmp_kick, 0);
        chk("R1 rd_seg", rd_seg, 0);
    endtask

    task automatic t_default_run();
        rd_step(1, "R3 d1"); rd_step(2, "R3 d2"); rd_step(3, "R3 d3");
        rd_step(0, "R3 d4"); rd_step(1, "R3 d5");
        chk("R2 wr untouched by reads", wr_seg, 0);
        wr_step(1, "R2 w1");
        chk("R2 rd untouched by writes", rd_seg, 1);
    endtask

    task automatic t_limits();
        load(pk(1, 2, 1, 0, 3, 0));
        chk("R6 readback", cfg_rdata, pk(1, 2, 1, 0, 3, 0));
        rd_step(2, "R3 lim1"); rd_step(1, "R3 lim2"); rd_step(2, "R3 lim3");
    endtask

    task automatic t_above();
        load(pk(3, 1, 0, 0, 3, 0));
        rd_step(0, "R3 above1"); rd_step(1, "R3 above2"); rd_step(0, "R3 above3");
    endtask

    task automatic t_inverted();
        load(pk(0, 0, 2, 1, 1, 3));
        rd_step(2, "R4 r1"); rd_step(3, "R4 r2"); rd_step(0, "R4 r3"); rd_step(2, "R4 r4");
        wr_step(3, "R4 w1"); wr_step(0, "R4 w2"); wr_step(1, "R4 w3"); wr_step(3, "R4 w4");
    endtask

    task automatic t_reload();
        load(pk(2, 3, 1, 3, 3, 2));
        rsc_cmd = 1;
        cyc();
        chk("R5 reload", cfg_rdata, pk(1, 3, 1, 2, 3, 2));
    endtask

    task automatic t_zero_bits();
        load(16'hFFFF);
        chk("R7 zero bits", cfg_rdata, 16'h7BDB);
    endtask

    task automatic t_priority();
        load(pk(2, 3, 0, 1, 3, 0));
        cfg_wr = 1; cfg_wdata = pk(3, 3, 1, 2, 3, 1); rsc_cmd = 1; rd_cycle = 1; wr_cycle = 1;
        cyc();
        chk("R8 load wins", cfg_rdata, pk(3, 3, 1, 2, 3, 1));
        rsc_cmd = 1; rd_cycle = 1; wr_cycle = 1;
        cyc();
        chk("R8 reload beats step", cfg_rdata, pk(1, 3, 1, 1, 3, 1));
    endtask

    task automatic t_steer();
        rd_word = 64'hDDDD_CCCC_BBBB_AAAA;
        for (int k = 0; k < 4; k++) begin
            load(pk(2'(k), 3, 0, 2'(3 - k), 3, 0));
            chk("R9 rd_data", rd_data, rd_word[k*16 +: 16]);
            chk("R9 wr_lane", wr_lane, 4'b1 << (3 - k));
        end
    endtask

    task automatic t_kick();
        load(pk(3, 3, 0, 0, 3, 0));
        rd_cycle = 1;
        cyc();
        chk("R10 read at 3 no kick", cmp_kick, 0);
        wr_step(1, "R10 w0"); chk("R10 no kick 0", cmp_kick, 0);
        wr_step(2, "R10 w1"); chk("R10 no kick 1", cmp_kick, 0);
        wr_step(3, "R10 w2"); chk("R10 no kick 2", cmp_kick, 0);
        wr_step(0, "R10 w3"); chk("R10 kick", cmp_kick, 1);
        cyc();
        chk("R10 kick one cycle", cmp_kick, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst = 1; cfg_wr = 0; cfg_wdata = '0; rsc_cmd = 0;
        rd_cycle = 0; wr_cycle = 0; rd_word = 64'h4444_3333_2222_1111;
        t_reset();
        chk("R9 reset lane", rd_data, 16'h1111);
        t_default_run();
        t_limits();
        t_above();
        t_inverted();
        t_reload();
        t_zero_bits();
        t_priority();
        t_steer();
        t_kick();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule